// File: doc/BRIEF.md
# Masked Pattern Match Trigger Unit

This block watches a wide bus of independent single-bit signals and compares each sample against two separately programmed value/mask pattern sets. The first set is a pattern detector: it reports a single-cycle hit when its pattern first appears and can ask an external timestamp source for a timestamp. The second set is a cross-trigger detector: it drives a trigger output and can also ask for a timestamp. Both sets examine the same bus sample in the same cycle.

Software programs the block through a small write-only register port. The port loads the value and mask words for each set, a global enable bit, and a mode word that holds the timestamp enables and the type bits. A clear command returns all pattern words and mode bits to their defaults in one write. The timestamp counter, trace packet assembly and bus fabric all sit outside the block. The block drives only three single-bit event outputs.

Top module: `patmatch_trig`

## Requirements
- R1: After reset, all three outputs are 0, the enable bit is 0, every value and mask word is 0, and the mode bits are at their defaults: pattern timestamp enable 0, pattern type 0, trigger type 0, trigger timestamp enable 1.
- R2: A write with address bit 5 = 0 loads one 32-bit word. Bit 4 selects the set (0 = pattern, 1 = trigger), bit 3 selects mask (1) or value (0), and bits 2:0 give the word index. Word i covers bus bits 32i+31 down to 32i.
- R3: Only bus bits whose mask bit is 1 take part in the compare. Bits with mask 0 are ignored, so changing them does not change the outputs.
- R4: A set whose mask words are all zero never reports a match.
- R5: The outputs reflect the bus sample taken at a clock edge, are valid right after that edge, and stay until the next edge.
- R6: `patt_hit_o` is high only in the first cycle of a run of consecutive pattern matches. A new pulse needs at least one non-matching sample in between.
- R7: Address 0x21 data bit 3 is the trigger type. With type 0, `trig_o` pulses on the first matching cycle only. With type 1, `trig_o` is high on every matching cycle.
- R8: Address 0x21 bit 0 enables pattern timestamps and bit 1 is the pattern type. With the enable at 1, a pattern match requests a timestamp on its first cycle (type 0) or on every matching cycle (type 1). With the enable at 0, the type bit has no effect.
- R9: Address 0x21 bit 2 enables trigger timestamps. While it is 1, every cycle in which `trig_o` is high also raises `ts_req_o`.
- R10: Address 0x20 bit 0 is the enable. While it is 0, no output is raised. When the enable is set again while a pattern is already present, that pattern is reported as a first-cycle match.
- R11: A write of data bit 0 = 1 to address 0x22 clears every value and mask word and restores the default mode bits from R1. The enable bit is left unchanged.
- R12: The two sets are independent. When both fire in the same cycle, both outputs are high and `ts_req_o` is a single 1 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 6 | Register write address |
| wr_data_i | input | 32 | Register write data |
| bus_i | input | 256 | Discrete-bit bus under observation |
| patt_hit_o | output | 1 | Pattern set first-match pulse |
| trig_o | output | 1 | Trigger set match output (pulse or level, by type) |
| ts_req_o | output | 1 | Timestamp request from either set |

## Verification
The pattern set and the trigger set can both match in the same cycle, and both can request a timestamp at that moment. The bench forces this by programming the two sets on disjoint bits and driving a bus sample that satisfies both. In the random phase it also places both patterns on the bus together. In those cycles, both event outputs must be high and the timestamp request must be a single 1. A reference model that evaluates each set separately and then ORs their timestamp requests judges every cycle, including cycles where a register write lands on the same edge as a match.

// File: rtl/patmatch_pkg.sv
// Package: shared constants and types for the masked pattern match trigger.
// Assumes: exactly two pattern sets, index 0 = pattern, index 1 = trigger.
package patmatch_pkg;

    localparam int unsigned NSETS    = 2;
    localparam int unsigned SET_PATT = 0;
    localparam int unsigned SET_TRIG = 1;

    // Sub-select inside the control region (low two address bits).
    localparam logic [1:0] CSEL_ENABLE = 2'd0;
    localparam logic [1:0] CSEL_MODE   = 2'd1;
    localparam logic [1:0] CSEL_CLEAR  = 2'd2;

    // Mode word, bit 0 first: patt_ts_en, patt_type, trig_ts_en, trig_type.
    typedef struct packed {
        logic trig_type;
        logic trig_ts_en;
        logic patt_type;
        logic patt_ts_en;
    } pm_mode_t;

    localparam pm_mode_t MODE_DEFAULT = '{
        trig_type:  1'b0,
        trig_ts_en: 1'b1,
        patt_type:  1'b0,
        patt_ts_en: 1'b0
    };

endpackage

// File: rtl/pm_cfg_regs.sv
// Module: pm_cfg_regs
// Holds the value and mask words of both sets, the enable bit and the mode
// word. Decodes the write-only register port.
// Assumes: BUS_W is a multiple of WORD_W and holds at least two words.
// Writes take effect on the edge that samples them.
module pm_cfg_regs
    import patmatch_pkg::*;
#(
    parameter  int unsigned BUS_W  = 256,
    parameter  int unsigned WORD_W = 32,
    localparam int unsigned NWORDS = BUS_W / WORD_W,
    localparam int unsigned WIDX_W = $clog2(NWORDS),
    localparam int unsigned ADDR_W = WIDX_W + 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en_i,
    input  logic [ADDR_W-1:0]            wr_addr_i,
    input  logic [WORD_W-1:0]            wr_data_i,
    output logic [NSETS-1:0][BUS_W-1:0]  val_o,
    output logic [NSETS-1:0][BUS_W-1:0]  mask_o,
    output logic                         enable_o,
    output pm_mode_t                     mode_o
);

    logic [NSETS-1:0][BUS_W-1:0] val_q;
    logic [NSETS-1:0][BUS_W-1:0] mask_q;
    logic                        enable_q;
    pm_mode_t                    mode_q;

    logic              ctrl_space;
    logic              set_sel;
    logic              mask_sel;
    logic [WIDX_W-1:0] widx;
    logic [1:0]        csel;
    logic              word_wr;
    logic              enable_wr;
    logic              mode_wr;
    logic              clear_req;

    // Address decode: region, set, value/mask and word index.
    always_comb begin
        ctrl_space = wr_addr_i[ADDR_W-1];
        set_sel    = wr_addr_i[ADDR_W-2];
        mask_sel   = wr_addr_i[ADDR_W-3];
        widx       = wr_addr_i[WIDX_W-1:0];
        csel       = wr_addr_i[1:0];
        word_wr    = wr_en_i && !ctrl_space;
        enable_wr  = wr_en_i && ctrl_space && (csel == CSEL_ENABLE);
        mode_wr    = wr_en_i && ctrl_space && (csel == CSEL_MODE);
        clear_req  = wr_en_i && ctrl_space && (csel == CSEL_CLEAR) && wr_data_i[0];
    end

    // Pattern word storage: cleared by reset or by the clear command.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_req) begin
            val_q  <= '0;
            mask_q <= '0;
        end else if (word_wr) begin
            if (mask_sel) begin
                mask_q[set_sel][widx*WORD_W +: WORD_W] <= wr_data_i;
            end else begin
                val_q[set_sel][widx*WORD_W +: WORD_W] <= wr_data_i;
            end
        end
    end

    // Enable bit: changed only by its own address, kept across a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= 1'b0;
        end else if (enable_wr) begin
            enable_q <= wr_data_i[0];
        end
    end

    // Mode word: reset and clear both restore the defaults.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_req) begin
            mode_q <= MODE_DEFAULT;
        end else if (mode_wr) begin
            mode_q <= pm_mode_t'(wr_data_i[3:0]);
        end
    end

    assign val_o    = val_q;
    assign mask_o   = mask_q;
    assign enable_o = enable_q;
    assign mode_o   = mode_q;

    AST_TRIG_TS_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> mode_q.trig_ts_en); // R1
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clear_req |=> (mask_q == '0) && (val_q == '0)); // R11
    AST_CLEAR_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        clear_req |=> (mode_q == MODE_DEFAULT)); // R11
    AST_CLEAR_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        clear_req |=> $stable(enable_q)); // R11

endmodule

// File: rtl/pm_comparator.sv
// Module: pm_comparator
// Compares one bus sample against one value/mask set word by word. Gives a
// registered level (match now) and a registered first-cycle pulse.
// Assumes: a mask of all zeros means "never match", not "always match".
module pm_comparator #(
    parameter  int unsigned BUS_W  = 256,
    parameter  int unsigned WORD_W = 32,
    localparam int unsigned NWORDS = BUS_W / WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [BUS_W-1:0] bus_i,
    input  logic [BUS_W-1:0] val_i,
    input  logic [BUS_W-1:0] mask_i,
    output logic             lvl_o,
    output logic             rise_o
);

    logic [NWORDS-1:0] word_ok;
    logic [NWORDS-1:0] word_used;
    logic              cmp_now;
    logic              lvl_q;
    logic              rise_q;

    // Per-word masked equality and "any mask bit set" flags.
    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        assign word_ok[w]   = ((bus_i[w*WORD_W +: WORD_W] ^ val_i[w*WORD_W +: WORD_W])
                              & mask_i[w*WORD_W +: WORD_W]) == '0;
        assign word_used[w] = |mask_i[w*WORD_W +: WORD_W];
    end

    // Combine: enabled, at least one bit compared, every word agrees.
    always_comb begin
        cmp_now = en_i && (|word_used) && (&word_ok);
    end

    // Register the level and the first-cycle edge of the match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q  <= 1'b0;
            rise_q <= 1'b0;
        end else begin
            lvl_q  <= cmp_now;
            rise_q <= cmp_now && !lvl_q;
        end
    end

    assign lvl_o  = lvl_q;
    assign rise_o = rise_q;

    AST_ZERO_MASK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_i == '0) |=> !lvl_q); // R4
    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !lvl_q && !rise_q); // R10
    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_q |=> !rise_q); // R6

endmodule

// File: rtl/pm_event_gen.sv
// Module: pm_event_gen
// Turns the registered match level and pulse of both sets into the hit,
// trigger and timestamp-request outputs, using the mode bits.
// Assumes: inputs come straight from registers, so the outputs are a
// mux of registered signals and carry no extra latency.
module pm_event_gen
    import patmatch_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  pm_mode_t mode_i,
    input  logic     p_lvl_i,
    input  logic     p_rise_i,
    input  logic     t_lvl_i,
    input  logic     t_rise_i,
    output logic     patt_hit_o,
    output logic     trig_o,
    output logic     ts_req_o
);

    logic patt_ts;
    logic trig_ts;

    // Select pulse or level per type bit and gate the timestamp sources.
    always_comb begin
        patt_hit_o = p_rise_i;
        trig_o     = mode_i.trig_type ? t_lvl_i : t_rise_i;
        patt_ts    = mode_i.patt_ts_en && (mode_i.patt_type ? p_lvl_i : p_rise_i);
        trig_ts    = mode_i.trig_ts_en && trig_o;
        ts_req_o   = patt_ts || trig_ts;
    end

    AST_TS_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        ts_req_o |-> (p_lvl_i || t_lvl_i)); // R8
    AST_TRIG_EDGE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_o && !mode_i.trig_type) |=> (!trig_o || mode_i.trig_type)); // R7
    AST_HIT_HAS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        patt_hit_o |-> p_lvl_i); // R6

endmodule

// File: rtl/patmatch_trig.sv
// Module: patmatch_trig (top)
// Masked pattern match trigger: a pattern set and a cross-trigger set
// compared against one discrete-bit bus, with timestamp requests.
// Assumes: the register port is synchronous to clk and write-only.
module patmatch_trig
    import patmatch_pkg::*;
#(
    parameter  int unsigned BUS_W  = 256,
    parameter  int unsigned WORD_W = 32,
    localparam int unsigned NWORDS = BUS_W / WORD_W,
    localparam int unsigned WIDX_W = $clog2(NWORDS),
    localparam int unsigned ADDR_W = WIDX_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic [BUS_W-1:0]  bus_i,
    output logic              patt_hit_o,
    output logic              trig_o,
    output logic              ts_req_o
);

    logic [NSETS-1:0][BUS_W-1:0] set_val;
    logic [NSETS-1:0][BUS_W-1:0] set_mask;
    logic                        enable;
    pm_mode_t                    mode;
    logic [NSETS-1:0]            set_lvl;
    logic [NSETS-1:0]            set_rise;

    pm_cfg_regs #(.BUS_W(BUS_W), .WORD_W(WORD_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .val_o     (set_val),
        .mask_o    (set_mask),
        .enable_o  (enable),
        .mode_o    (mode)
    );

    // One comparator per set, all sharing the same bus sample.
    for (genvar s = 0; s < NSETS; s++) begin : g_set
        pm_comparator #(.BUS_W(BUS_W), .WORD_W(WORD_W)) u_cmp (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_i   (enable),
            .bus_i  (bus_i),
            .val_i  (set_val[s]),
            .mask_i (set_mask[s]),
            .lvl_o  (set_lvl[s]),
            .rise_o (set_rise[s])
        );
    end

    pm_event_gen u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode),
        .p_lvl_i    (set_lvl[SET_PATT]),
        .p_rise_i   (set_rise[SET_PATT]),
        .t_lvl_i    (set_lvl[SET_TRIG]),
        .t_rise_i   (set_rise[SET_TRIG]),
        .patt_hit_o (patt_hit_o),
        .trig_o     (trig_o),
        .ts_req_o   (ts_req_o)
    );

    AST_BOTH_TS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (patt_hit_o && trig_o && mode.trig_ts_en) |-> ts_req_o); // R12
    AST_OFF_NO_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !trig_o && !patt_hit_o); // R10

endmodule

// File: tb/patmatch_trig_tb.sv
// Bench: directed corner cases plus seeded random stimulus, each cycle
// compared against a reference model built from the requirements.
module patmatch_trig_tb_top;

    localparam int BUS_W  = 256;
    localparam int WORD_W = 32;
    localparam int AW     = 6;
    localparam logic [AW-1:0] A_EN   = 6'h20;
    localparam logic [AW-1:0] A_MODE = 6'h21;
    localparam logic [AW-1:0] A_CLR  = 6'h22;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [AW-1:0]     wr_addr = '0;
    logic [WORD_W-1:0] wr_data = '0;
    logic [BUS_W-1:0]  bus = '0;
    logic              patt_hit, trig, ts_req;

    always #4 clk = ~clk;

    patmatch_trig dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .bus_i(bus), .patt_hit_o(patt_hit),
        .trig_o(trig), .ts_req_o(ts_req)
    );

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    bit          done  = 1'b0;

    // Reference model state.
    logic [BUS_W-1:0] m_val [2];
    logic [BUS_W-1:0] m_mask[2];
    logic m_en, m_pts, m_ptype, m_tts, m_ttype;
    logic mp_lvl, mp_rise, mt_lvl, mt_rise;

    function automatic logic f_hit(logic [BUS_W-1:0] b, logic [BUS_W-1:0] v,
                                   logic [BUS_W-1:0] m);
        return (m != '0) && (((b ^ v) & m) == '0);
    endfunction

    function automatic logic [AW-1:0] f_addr(int set, int is_mask, int w);
        return {1'b0, set[0], is_mask[0], w[2:0]};
    endfunction

    function automatic logic [BUS_W-1:0] f_rand_bus();
        logic [BUS_W-1:0] b;
        for (int i = 0; i < BUS_W / 32; i++) b[i*32 +: 32] = $urandom;
        return b;
    endfunction

    function automatic logic [BUS_W-1:0] f_put(logic [BUS_W-1:0] b, int w,
                                               logic [31:0] x);
        logic [BUS_W-1:0] r = b;
        r[w*32 +: 32] = x;
        return r;
    endfunction

    task automatic model_defaults();
        for (int s = 0; s < 2; s++) begin m_val[s] = '0; m_mask[s] = '0; end
        m_pts = 1'b0; m_ptype = 1'b0; m_tts = 1'b1; m_ttype = 1'b0;
    endtask

    task automatic model_write(logic [AW-1:0] a, logic [31:0] d);
        if (!a[5]) begin
            if (a[3]) m_mask[a[4]][a[2:0]*32 +: 32] = d;
            else      m_val[a[4]][a[2:0]*32 +: 32]  = d;
        end else if (a[1:0] == 2'd0) begin
            m_en = d[0];
        end else if (a[1:0] == 2'd1) begin
            m_pts = d[0]; m_ptype = d[1]; m_tts = d[2]; m_ttype = d[3];
        end else if (a[1:0] == 2'd2 && d[0]) begin
            model_defaults();
        end
    endtask

    task automatic check(string tag);
        logic [2:0] exp, act;
        logic et;
        et  = m_ttype ? mt_lvl : mt_rise;
        exp = {mp_rise, et, (m_pts & (m_ptype ? mp_lvl : mp_rise)) | (m_tts & et)};
        act = {patt_hit, trig, ts_req};
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: {hit,trig,ts} actual %b expected %b",
                     tag, n_vec, act, exp);
        end
    endtask

    // One clock: drive at negedge, advance model, compare after the edge.
    task automatic step(logic [BUS_W-1:0] b, logic we, logic [AW-1:0] a,
                        logic [31:0] d, string tag);
        logic np, nt;
        bus = b; wr_en = we; wr_addr = a; wr_data = d;
        np = m_en & f_hit(b, m_val[0], m_mask[0]);
        nt = m_en & f_hit(b, m_val[1], m_mask[1]);
        mp_rise = np & ~mp_lvl; mp_lvl = np;
        mt_rise = nt & ~mt_lvl; mt_lvl = nt;
        if (we) model_write(a, d);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        check(tag);
    endtask

    task automatic idle(logic [BUS_W-1:0] b, string tag);
        step(b, 1'b0, '0, '0, tag);
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d, string tag);
        step(bus, 1'b1, a, d, tag);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired after %0d vectors", n_vec);
            summary();
        end
    end

    initial begin : main
        logic [BUS_W-1:0] pbus, tbus, b;
        void'($urandom(32'h5EED_0042));
        model_defaults();
        m_en = 1'b0; mp_lvl = 0; mp_rise = 0; mt_lvl = 0; mt_rise = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, no outputs on random bus.
        for (int i = 0; i < 3; i++) idle(f_rand_bus(), "R1");

        // R4: enabled with all-zero masks, bus of zeros equals all values.
        wr(A_EN, 32'h1, "R4");
        for (int i = 0; i < 3; i++) idle('0, "R4");
        for (int i = 0; i < 3; i++) idle(f_rand_bus(), "R4");

        // R2: pattern word 3 compared on bits 15:12.
        wr(f_addr(0, 1, 3), 32'h0000_F000, "R2");
        wr(f_addr(0, 0, 3), 32'h0000_A000, "R2");
        pbus = f_put('0, 3, 32'h0000_A000);
        idle(pbus, "R2");
        // R3, R6: unmasked bits move, masked bits hold -> one pulse only.
        for (int i = 0; i < 4; i++) begin
            b = f_rand_bus();
            b[3*32 + 12 +: 4] = 4'hA;
            idle(b, "R3");
        end
        idle(f_put(pbus, 3, 32'h0000_B000), "R6");
        idle(pbus, "R6");
        idle(pbus, "R6");

        // R5: a single-cycle pattern shows right after its edge only.
        idle('0, "R5");
        idle(pbus, "R5");
        idle('0, "R5");

        // R1, R9: trigger set with default trigger timestamp enable.
        wr(f_addr(1, 1, 7), 32'hFF00_0000, "R9");
        wr(f_addr(1, 0, 7), 32'h3C00_0000, "R9");
        tbus = f_put('0, 7, 32'h3C00_0000);
        idle(tbus, "R1");
        idle(tbus, "R9");
        idle('0, "R9");

        // R7: trigger type level.
        wr(A_MODE, 32'h0000_000C, "R7");
        for (int i = 0; i < 3; i++) idle(tbus, "R7");
        idle('0, "R7");

        // R8: pattern timestamps, type 0 then type 1, and ts off.
        wr(A_MODE, 32'h0000_0001, "R8");
        for (int i = 0; i < 3; i++) idle(pbus, "R8");
        idle('0, "R8");
        wr(A_MODE, 32'h0000_0003, "R8");
        for (int i = 0; i < 3; i++) idle(pbus, "R8");
        wr(A_MODE, 32'h0000_0002, "R8");
        idle(pbus, "R8");
        idle('0, "R8");

        // R12: both sets in the same cycle.
        wr(A_MODE, 32'h0000_0005, "R12");
        b = pbus | tbus;
        idle(b, "R12");
        idle(b, "R12");
        idle('0, "R12");

        // R10: disable while matching, re-enable with pattern present.
        idle(b, "R10");
        wr(A_EN, 32'h0, "R10");
        idle(b, "R10");
        idle(b, "R10");
        wr(A_EN, 32'h1, "R10");
        idle(b, "R10");
        idle('0, "R10");

        // R11: clear keeps enable, restores default trigger timestamp.
        wr(A_CLR, 32'h1, "R11");
        idle(b, "R11");
        idle('0, "R11");
        wr(f_addr(1, 1, 0), 32'h0000_0001, "R11");
        idle(f_put('0, 0, 32'h0), "R11");
        idle(f_put('0, 0, 32'h1), "R11");
        idle(f_put('0, 0, 32'h0), "R11");
        wr(A_CLR, 32'h0, "R11");
        idle('0, "R11");

        // Random mix: sparse masks, forced matches, occasional writes.
        for (int it = 0; it < 3000; it++) begin
            int r;
            r = $urandom % 100;
            if (r < 4) begin
                wr(f_addr($urandom % 2, 1, $urandom % 8),
                   (32'h1 << ($urandom % 32)) | (32'h1 << ($urandom % 32)), "R12");
            end else if (r < 8) begin
                wr(f_addr($urandom % 2, 0, $urandom % 8), $urandom, "R12");
            end else if (r < 10) begin
                wr(A_MODE, $urandom % 16, "R12");
            end else if (r < 11) begin
                wr(A_EN, $urandom % 4 != 0, "R10");
            end else if (r < 12) begin
                wr(A_CLR, $urandom % 2, "R11");
            end else begin
                b = f_rand_bus();
                if ($urandom % 2) b = (b & ~m_mask[0]) | (m_val[0] & m_mask[0]);
                if ($urandom % 2) b = (b & ~m_mask[1]) | (m_val[1] & m_mask[1]);
                idle(b, "R12");
            end
        end

        done = 1'b1;
        summary();
    end

endmodule